// File: doc/BRIEF.md
# Bus-Attached General-Purpose Pin Port

This block gives a processor eight general-purpose pins through a Wishbone classic slave port with an 8-bit data path. Each pin is set as an input or an output by a direction register. A second register, the line register, carries the level that output pins drive. When read, it reports the driven level for output pins and the sampled pin level for input pins. Every incoming pin passes through two flip-flops in series before any logic sees it, so slow or noisy levels from off-chip do not reach the bus as metastable values.

A parameter chooses how many of the eight pins exist, counting upward from bit 0. The bits above that count do not exist in either register. They read as zero and keep no written value. Accesses complete with no wait states: the acknowledge comes one clock after the master raises its request, and the read data is valid in that same cycle.

Top module: `gpio_wb_port`

## Requirements
- R1: `ack_o` goes high in the cycle after the first clock edge at which `cyc_i` and `stb_i` are both high. It stays high for exactly one cycle, and it does not rise again while that same request stays high.
- R2: While `rst_i` is high, and after it is released, the direction register and the line register are zero. All pins are inputs (`pin_oe_o` = 0), `pin_out_o` = 0 and `ack_o` is low.
- R3: Address 0 selects the direction register. A written bit of 1 makes its pin an output and sets bit n of `pin_oe_o`, and 0 makes it an input. A read of address 0 returns the stored value.
- R4: Address 1 selects the line register. For an output pin, a written bit sets that pin's level on `pin_out_o`, and a read returns that driven level.
- R5: A line-register write to a bit whose pin is an input leaves that bit unchanged. This is visible on `pin_out_o` when the pin is later made an output.
- R6: For an input pin, a read of address 1 returns the pin level after two flip-flop stages. A read captured at the first edge after the pin changes still returns the old level. A read issued two or more cycles after the change returns the new level.
- R7: With parameter IO (1 to 8), bits IO to 7 of `dat_o`, `pin_oe_o` and `pin_out_o` are always zero, and writes to those bits are dropped.
- R8: Any address other than 0 or 1 reads as zero, and a write to it changes no register.
- R9: A register changes only on an acknowledged access with `we_i` high. An access with `we_i` low leaves both registers unchanged, whatever is on `dat_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Transfer strobe |
| adr_i | input | ADR_W | Register address: 0 direction, 1 line |
| we_i | input | 1 | Write enable |
| dat_i | input | 8 | Write data |
| dat_o | output | 8 | Read data, valid while `ack_o` is high |
| ack_o | output | 1 | Transfer acknowledge |
| pin_in_i | input | 8 | Raw pin levels from the pads |
| pin_out_o | output | 8 | Levels driven onto output pins |
| pin_oe_o | output | 8 | Output enable per pin, 1 = output |

## Verification
The bench builds the block with IO = 6 and ADR_W = 2. IO = 6 leaves two unimplemented top bits, so the forced-zero reads and dropped writes can be observed. ADR_W = 2 makes addresses 2 and 3 reachable, so accesses outside the two registers can be tried. Under this setup the bench mixes input and output pins in one byte, checks the two-stage latency of the input path, and holds a strobe high to confirm that only one acknowledge is issued.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              ack;
        logic              seen;
    } hs_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] dir;
        logic [BYTE_W-1:0] lvl;
        logic [BYTE_W-1:0] rdata;
    } reg_state_t;

    function automatic logic [BYTE_W-1:0] impl_mask(input int unsigned n);
        logic [BYTE_W:0] full;
        full = (BYTE_W+1)'(1) << n;
        return BYTE_W'(full - 1'b1);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [1:0] stage_d, stage_q;

        always_comb begin
            stage_d = {stage_q[0], raw_i[b]};
        end

        always_ff @(posedge clk_i) begin
            if (rst_i) stage_q <= '0;
            else       stage_q <= stage_d;
        end

        assign sync_o[b] = stage_q[1];
    end

endmodule

// File: rtl/gpio_handshake.sv
module gpio_handshake
    import gpio_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic cyc_i,
    input  logic stb_i,
    output logic fire_o,
    output logic ack_o
);

    hs_state_t st_d, st_q;
    logic      req;

    always_comb begin
        req     = cyc_i & stb_i;
        fire_o  = req & ~st_q.seen;
        st_d    = st_q;
        st_d.ack  = fire_o;
        st_d.seen = req;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign ack_o = st_q.ack;

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int IO    = 8,
    parameter int ADR_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              fire_i,
    input  logic              we_i,
    input  logic [ADR_W-1:0]  adr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [BYTE_W-1:0] pin_sync_i,
    output logic [BYTE_W-1:0] dir_o,
    output logic [BYTE_W-1:0] lvl_o,
    output logic [BYTE_W-1:0] rdata_o
);

    localparam logic [BYTE_W-1:0] MASK      = impl_mask(IO);
    localparam logic [ADR_W-1:0]  ADDR_DIR  = ADR_W'(0);
    localparam logic [ADR_W-1:0]  ADDR_LVL  = ADR_W'(1);

    reg_state_t st_d, st_q;
    logic       sel_dir, sel_lvl;
    logic [BYTE_W-1:0] wr_bits;
    logic [BYTE_W-1:0] lvl_view;

    always_comb begin
        sel_dir  = (adr_i == ADDR_DIR);
        sel_lvl  = (adr_i == ADDR_LVL);
        wr_bits  = st_q.dir & MASK;
        lvl_view = ((st_q.dir & st_q.lvl) | (~st_q.dir & pin_sync_i)) & MASK;

        st_d = st_q;
        if (fire_i) begin
            if (we_i && sel_dir) st_d.dir = wdata_i & MASK;
            if (we_i && sel_lvl) st_d.lvl = (st_q.lvl & ~wr_bits) | (wdata_i & wr_bits);
            if (sel_dir)      st_d.rdata = st_q.dir & MASK;
            else if (sel_lvl) st_d.rdata = lvl_view;
            else              st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign dir_o   = st_q.dir & MASK;
    assign lvl_o   = st_q.lvl & MASK;
    assign rdata_o = st_q.rdata;

endmodule

// File: rtl/gpio_wb_port.sv
module gpio_wb_port
    import gpio_pkg::*;
#(
    parameter int IO    = 8,
    parameter int ADR_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cyc_i,
    input  logic             stb_i,
    input  logic [ADR_W-1:0] adr_i,
    input  logic             we_i,
    input  logic [7:0]       dat_i,
    output logic [7:0]       dat_o,
    output logic             ack_o,
    input  logic [7:0]       pin_in_i,
    output logic [7:0]       pin_out_o,
    output logic [7:0]       pin_oe_o
);

    logic             fire;
    logic [BYTE_W-1:0] pin_sync;
    logic [BYTE_W-1:0] dir, lvl;

    gpio_sync #(.W(BYTE_W)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .raw_i  (pin_in_i),
        .sync_o (pin_sync)
    );

    gpio_handshake u_hs (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .cyc_i  (cyc_i),
        .stb_i  (stb_i),
        .fire_o (fire),
        .ack_o  (ack_o)
    );

    gpio_regs #(.IO(IO), .ADR_W(ADR_W)) u_regs (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .fire_i     (fire),
        .we_i       (we_i),
        .adr_i      (adr_i),
        .wdata_i    (dat_i),
        .pin_sync_i (pin_sync),
        .dir_o      (dir),
        .lvl_o      (lvl),
        .rdata_o    (dat_o)
    );

    assign pin_oe_o  = dir;
    assign pin_out_o = lvl;

endmodule

// File: rtl/gpio_wb_port_chk.sv
module gpio_wb_port_chk #(
    parameter int IO    = 8,
    parameter int ADR_W = 2
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             cyc_i,
    input logic             stb_i,
    input logic             we_i,
    input logic [7:0]       dat_o,
    input logic             ack_o,
    input logic [7:0]       pin_out_o,
    input logic [7:0]       pin_oe_o
);

    localparam logic [7:0] MASK = gpio_pkg::impl_mask(IO);

    p_ack_single_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        ack_o |=> !ack_o);

    p_ack_after_req_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        ack_o |-> $past(cyc_i && stb_i));

    p_reset_clear_r2: assert property (@(posedge clk_i)
        rst_i |=> (pin_oe_o == 8'h00 && pin_out_o == 8'h00 && !ack_o));

    p_dir_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !(cyc_i && stb_i && we_i) |=> $stable(pin_oe_o));

    p_lvl_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !(cyc_i && stb_i && we_i) |=> $stable(pin_out_o));

    p_unimpl_zero_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        ((dat_o | pin_oe_o | pin_out_o) & ~MASK) == 8'h00);

endmodule

bind gpio_wb_port gpio_wb_port_chk #(.IO(IO), .ADR_W(ADR_W)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .cyc_i     (cyc_i),
    .stb_i     (stb_i),
    .we_i      (we_i),
    .dat_o     (dat_o),
    .ack_o     (ack_o),
    .pin_out_o (pin_out_o),
    .pin_oe_o  (pin_oe_o)
);

// File: tb/gpio_wb_port_tb.sv
module gpio_wb_port_tb;

    localparam int         IO    = 6;
    localparam int         ADR_W = 2;
    localparam logic [7:0] MASK  = 8'h3F;

    logic             clk_i = 1'b0;
    logic             rst_i = 1'b1;
    logic             cyc_i = 1'b0;
    logic             stb_i = 1'b0;
    logic [ADR_W-1:0] adr_i = '0;
    logic             we_i  = 1'b0;
    logic [7:0]       dat_i = '0;
    logic [7:0]       dat_o;
    logic             ack_o;
    logic [7:0]       pin_in_i = '0;
    logic [7:0]       pin_out_o;
    logic [7:0]       pin_oe_o;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;
    logic tb_we = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk_i = ~clk_i;

    gpio_wb_port #(.IO(IO), .ADR_W(ADR_W)) u_dut (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // monitor: pops the expected read data when an acknowledged read appears
    always @(negedge clk_i) begin
        if (!rst_i && ack_o && !tb_we) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected read ack", 8'h01, 8'h00);
            end else begin
                check(tag_q.pop_front(), dat_o, exp_q.pop_front());
            end
        end
    end

    // driver: one access; hold adds cycles with the strobe still high
    task automatic access(input logic we, input logic [ADR_W-1:0] adr,
                          input logic [7:0] data, input logic [7:0] exp,
                          input string tag, input int hold);
        tb_we = we;
        if (!we) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        cyc_i = 1'b1; stb_i = 1'b1; we_i = we; adr_i = adr; dat_i = data;
        @(negedge clk_i);
        check("R1 ack after request", {7'd0, ack_o}, 8'h01);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk_i);
            check("R1 no second ack while held", {7'd0, ack_o}, 8'h00);
        end
        cyc_i = 1'b0; stb_i = 1'b0; we_i = 1'b0; dat_i = 8'h00;
        @(negedge clk_i);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        check("R2 oe after reset", pin_oe_o, 8'h00);
        check("R2 out after reset", pin_out_o, 8'h00);
        check("R2 ack after reset", {7'd0, ack_o}, 8'h00);
        rst_i = 1'b0;
        @(negedge clk_i);
        access(0, 2'd0, 8'h00, 8'h00, "R2 dir reads zero", 0);
        access(0, 2'd1, 8'h00, 8'h00, "R2 line reads zero", 0);

        // mixed directions: pins 0..3 out, 4..5 in
        pin_in_i = 8'hA0;
        access(1, 2'd0, 8'h0F, 8'h00, "", 0);
        check("R3 oe follows dir", pin_oe_o, 8'h0F);
        access(0, 2'd0, 8'h00, 8'h0F, "R3 dir readback", 0);
        access(1, 2'd1, 8'hFF, 8'h00, "", 0);
        check("R4 out level", pin_out_o, 8'h0F);
        access(0, 2'd1, 8'h00, 8'h2F, "R4 R6 mixed line read", 0);

        // all to output, upper bits dropped; input bits 4,5 were never stored
        access(1, 2'd0, 8'hFF, 8'h00, "", 0);
        check("R7 oe upper zero", pin_oe_o, MASK);
        access(0, 2'd0, 8'h00, MASK, "R7 dir read masked", 0);
        check("R5 input-mode write ignored", pin_out_o, 8'h0F);
        access(1, 2'd1, 8'hD5, 8'h00, "", 0);
        check("R4 R7 out masked", pin_out_o, 8'h15);
        access(0, 2'd1, 8'h00, 8'h15, "R4 output readback", 0);

        // read with write data present must not write
        access(0, 2'd0, 8'h00, MASK, "R9 read leaves dir", 0);
        check("R9 oe unchanged", pin_oe_o, MASK);
        access(0, 2'd1, 8'h3F, 8'h15, "R9 read leaves line", 0);
        check("R9 out unchanged", pin_out_o, 8'h15);

        // other addresses
        access(1, 2'd2, 8'hFF, 8'h00, "", 0);
        access(1, 2'd3, 8'h00, 8'h00, "", 0);
        check("R8 oe after stray write", pin_oe_o, MASK);
        check("R8 out after stray write", pin_out_o, 8'h15);
        access(0, 2'd2, 8'h00, 8'h00, "R8 addr 2 reads zero", 0);
        access(0, 2'd3, 8'h00, 8'h00, "R8 addr 3 reads zero", 0);

        // held strobe: one ack only
        access(0, 2'd0, 8'h00, MASK, "R1 held read data", 3);

        // input latency
        access(1, 2'd0, 8'h00, 8'h00, "", 0);
        check("R3 all inputs", pin_oe_o, 8'h00);
        pin_in_i = 8'h00;
        repeat (3) @(negedge clk_i);
        access(0, 2'd1, 8'h00, 8'h00, "R6 settled low", 0);
        pin_in_i = 8'hEA;
        access(0, 2'd1, 8'h00, 8'h00, "R6 first edge still old", 0);
        repeat (2) @(negedge clk_i);
        access(0, 2'd1, 8'h00, 8'h2A, "R6 R7 new level masked", 0);
        check("R5 out kept while input", pin_out_o, 8'h15);

        check("queue drained", 8'(exp_q.size()), 8'h00);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule